// File: doc/BRIEF.md
# Receive Object Allocator and Interrupt Prioritizer

This block holds a bank of message objects for a CAN controller. It takes each frame the protocol engine has accepted, filters it against the identifier and mask set up for every object, and writes it into the lowest-numbered object that can take it. It keeps the per-object flags for new data, pending interrupt, lost message and transmit request. It also produces the interrupt identifier that the host reads to learn what needs attention.

Objects that share a filter form a receive FIFO. Every object in the group has its end-of-buffer flag clear, except the last one, which has it set. A full object in the middle of a group is skipped. The last object is overwritten when the whole group is full. The host configures objects, clears flags and reads back stored frames through simple strobed ports. The transmit engine reports finished transmissions through a done strobe. A separate status interrupt input takes priority over every object in the identifier.

Top module: `rx_obj_bank`

## Requirements
- R1: After reset, newdat_o, intpnd_o, msglst_o and txrqst_o are all zero and int_id_o is 0.
- R2: A frame matches an object only when that object is valid and set for receive (tx flag 0). With the use-mask flag set, the frame ID must equal the filter ID on every bit where the mask is 1. With the use-mask flag clear, all bits must be equal. A frame that finds no eligible object changes no flag and no stored content.
- R3: A frame on rx_valid_i goes to the lowest-indexed eligible object. At the next clock edge that object's newdat_o and intpnd_o bits (bit i for index i) become 1. Its stored ID, DLC and data then read back on rd_*_o when rd_obj_i selects it.
- R4: An object whose end-of-buffer flag is clear is eligible only while its newdat bit is 0. A full object in a FIFO group is therefore skipped, and the next object in the group takes the frame.
- R5: An object whose end-of-buffer flag is set stays eligible while its newdat bit is 1. A store into it replaces the content and sets its msglst_o bit.
- R6: A frame that matches only full objects with the end-of-buffer flag clear is dropped. The stored content of those objects is kept.
- R7: clr_i clears the selected newdat, intpnd and msglst bits of object clr_obj_i. If a store hits the same object in the same cycle, the store's settings win.
- R8: While stat_int_i is 1, int_id_o reads 16'h8000.
- R9: Otherwise, int_id_o reads index+1 of the lowest object whose intpnd bit is set and whose interrupt enable is set. The enable is the rx enable for a receive object and the tx enable for a transmit object. int_id_o reads 0 when no object qualifies.
- R10: A config write with tx=1 and txrqst=1 sets that object's txrqst_o bit. tx_done_i on an object whose txrqst bit is set clears the bit and, when the tx enable is set, sets its intpnd bit.
- R11: A config write clears the newdat, intpnd and msglst bits of the object written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_obj_i | input | 5 | Object index to configure |
| cfg_valid_i | input | 1 | Object in use |
| cfg_tx_i | input | 1 | Object direction, 1 = transmit |
| cfg_id_i | input | 29 | Filter ID |
| cfg_mask_i | input | 29 | Filter mask, 1 = bit compared |
| cfg_umask_i | input | 1 | Apply mask |
| cfg_rxie_i | input | 1 | Receive interrupt enable |
| cfg_txie_i | input | 1 | Transmit interrupt enable |
| cfg_eob_i | input | 1 | Last object of a FIFO group |
| cfg_txrqst_i | input | 1 | Request transmission |
| rx_valid_i | input | 1 | Accepted frame strobe |
| rx_id_i | input | 29 | Frame ID |
| rx_dlc_i | input | 4 | Frame length code |
| rx_data_i | input | 64 | Frame payload |
| clr_i | input | 1 | Host flag clear strobe |
| clr_obj_i | input | 5 | Object to clear |
| clr_newdat_i | input | 1 | Clear newdat |
| clr_intpnd_i | input | 1 | Clear intpnd |
| clr_msglst_i | input | 1 | Clear msglst |
| tx_done_i | input | 1 | Transmission finished |
| tx_obj_i | input | 5 | Object that was sent |
| stat_int_i | input | 1 | Status interrupt pending |
| rd_obj_i | input | 5 | Object to read back |
| rd_id_o | output | 29 | Stored frame ID |
| rd_dlc_o | output | 4 | Stored DLC |
| rd_data_o | output | 64 | Stored payload |
| newdat_o | output | 32 | New-data flags, bit i = object i |
| intpnd_o | output | 32 | Pending flags |
| msglst_o | output | 32 | Lost-message flags |
| txrqst_o | output | 32 | Transmit request flags |
| int_id_o | output | 16 | Interrupt identifier |

## Verification
The bench fills a three-deep FIFO group until its last object is overwritten. An allocator that ignored the end-of-buffer flag would either overwrite the first slot or drop the frame without setting msglst. Near-miss frames are sent to an exact-match object, and a transmit object is given an ID that could otherwise match, so loose filtering would show up as stray newdat bits. The bench clears a pending flag in the same cycle a frame lands on that object, which catches clear-over-store priority. It checks that a pending object with its enable off is never reported and that the status code masks all object numbers. It also fills a group that has no end-of-buffer object, so a design that overwrote there instead of dropping would change the stored payload.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  typedef struct packed {
    logic valid;
    logic tx;
    logic umask;
    logic rxie;
    logic txie;
    logic eob;
  } obj_cfg_t;

  localparam logic [15:0] STAT_CODE = 16'h8000;
endpackage

// File: rtl/rx_prio_enc.sv
module rx_prio_enc #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rx_accept.sv
module rx_accept #(
  parameter int N    = 32,
  parameter int ID_W = 29
) (
  input  logic [N-1:0]           valid_i,
  input  logic [N-1:0]           tx_i,
  input  logic [N-1:0]           umask_i,
  input  logic [N-1:0]           eob_i,
  input  logic [N-1:0]           newdat_i,
  input  logic [N-1:0][ID_W-1:0] filt_id_i,
  input  logic [N-1:0][ID_W-1:0] mask_i,
  input  logic [ID_W-1:0]        rx_id_i,
  output logic [N-1:0]           elig_o
);
  for (genvar g = 0; g < N; g++) begin : g_obj
    logic [ID_W-1:0] cmp_mask;
    logic            match;
    assign cmp_mask = umask_i[g] ? mask_i[g] : '1;
    assign match    = valid_i[g] & ~tx_i[g] &
                      (((filt_id_i[g] ^ rx_id_i) & cmp_mask) == '0);
    // inside a FIFO group only the tail may be overwritten
    assign elig_o[g] = match & (~newdat_i[g] | eob_i[g]);
  end
endmodule

// File: rtl/rx_int_id.sv
module rx_int_id
  import can_rx_pkg::*;
#(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N),
  parameter int INT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stat_i,
  input  logic [N-1:0]     pend_i,
  output logic [INT_W-1:0] int_id_o
);
  logic             found;
  logic [IDX_W-1:0] idx;

  rx_prio_enc #(.N(N), .IDX_W(IDX_W)) u_enc (
    .req_i(pend_i), .found_o(found), .idx_o(idx)
  );

  always_comb begin
    if (stat_i)     int_id_o = STAT_CODE[INT_W-1:0];
    else if (found) int_id_o = INT_W'(idx) + INT_W'(1);
    else            int_id_o = '0;
  end

  // R8
  stat_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i |-> int_id_o == STAT_CODE[INT_W-1:0]);

  // R9
  pend_reported_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_i && int_id_o != '0) |-> pend_i[IDX_W'(int_id_o - INT_W'(1))]);

  // R9
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_i && pend_i == '0) |-> int_id_o == '0);
endmodule

// File: rtl/rx_obj_bank.sv
module rx_obj_bank
  import can_rx_pkg::*;
#(
  parameter int N      = 32,
  parameter int ID_W   = 29,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 64,
  parameter int INT_W  = 16,
  localparam int OBJ_W = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [OBJ_W-1:0]  cfg_obj_i,
  input  logic              cfg_valid_i,
  input  logic              cfg_tx_i,
  input  logic [ID_W-1:0]   cfg_id_i,
  input  logic [ID_W-1:0]   cfg_mask_i,
  input  logic              cfg_umask_i,
  input  logic              cfg_rxie_i,
  input  logic              cfg_txie_i,
  input  logic              cfg_eob_i,
  input  logic              cfg_txrqst_i,
  input  logic              rx_valid_i,
  input  logic [ID_W-1:0]   rx_id_i,
  input  logic [DLC_W-1:0]  rx_dlc_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              clr_i,
  input  logic [OBJ_W-1:0]  clr_obj_i,
  input  logic              clr_newdat_i,
  input  logic              clr_intpnd_i,
  input  logic              clr_msglst_i,
  input  logic              tx_done_i,
  input  logic [OBJ_W-1:0]  tx_obj_i,
  input  logic              stat_int_i,
  input  logic [OBJ_W-1:0]  rd_obj_i,
  output logic [ID_W-1:0]   rd_id_o,
  output logic [DLC_W-1:0]  rd_dlc_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [N-1:0]      newdat_o,
  output logic [N-1:0]      intpnd_o,
  output logic [N-1:0]      msglst_o,
  output logic [N-1:0]      txrqst_o,
  output logic [INT_W-1:0]  int_id_o
);
  obj_cfg_t [N-1:0]          cfg_q;
  logic [N-1:0][ID_W-1:0]    filt_q, mask_q, rxid_q;
  logic [N-1:0][DLC_W-1:0]   dlc_q;
  logic [N-1:0][DATA_W-1:0]  data_q;
  logic [N-1:0]              newdat_q, intpnd_q, msglst_q, txrqst_q;

  logic [N-1:0] valid_v, tx_v, umask_v, eob_v, elig, pend_en;
  logic             hit;
  logic [OBJ_W-1:0] hit_idx;

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign valid_v[g] = cfg_q[g].valid;
    assign tx_v[g]    = cfg_q[g].tx;
    assign umask_v[g] = cfg_q[g].umask;
    assign eob_v[g]   = cfg_q[g].eob;
    assign pend_en[g] = intpnd_q[g] & (cfg_q[g].tx ? cfg_q[g].txie : cfg_q[g].rxie);
  end

  rx_accept #(.N(N), .ID_W(ID_W)) u_acc (
    .valid_i(valid_v), .tx_i(tx_v), .umask_i(umask_v), .eob_i(eob_v),
    .newdat_i(newdat_q), .filt_id_i(filt_q), .mask_i(mask_q),
    .rx_id_i(rx_id_i), .elig_o(elig)
  );

  rx_prio_enc #(.N(N), .IDX_W(OBJ_W)) u_alloc (
    .req_i(elig), .found_o(hit), .idx_o(hit_idx)
  );

  rx_int_id #(.N(N), .IDX_W(OBJ_W), .INT_W(INT_W)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .stat_i(stat_int_i),
    .pend_i(pend_en), .int_id_o(int_id_o)
  );

  logic store;
  assign store = rx_valid_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      filt_q   <= '0;
      mask_q   <= '0;
      rxid_q   <= '0;
      dlc_q    <= '0;
      data_q   <= '0;
      newdat_q <= '0;
      intpnd_q <= '0;
      msglst_q <= '0;
      txrqst_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (cfg_we_i && cfg_obj_i == OBJ_W'(i)) begin
          cfg_q[i]    <= '{valid: cfg_valid_i, tx: cfg_tx_i, umask: cfg_umask_i,
                           rxie: cfg_rxie_i, txie: cfg_txie_i, eob: cfg_eob_i};
          filt_q[i]   <= cfg_id_i;
          mask_q[i]   <= cfg_mask_i;
          newdat_q[i] <= 1'b0;
          intpnd_q[i] <= 1'b0;
          msglst_q[i] <= 1'b0;
          txrqst_q[i] <= cfg_valid_i & cfg_tx_i & cfg_txrqst_i;
        end else begin
          if (clr_i && clr_obj_i == OBJ_W'(i)) begin
            if (clr_newdat_i) newdat_q[i] <= 1'b0;
            if (clr_intpnd_i) intpnd_q[i] <= 1'b0;
            if (clr_msglst_i) msglst_q[i] <= 1'b0;
          end
          if (tx_done_i && tx_obj_i == OBJ_W'(i) && txrqst_q[i]) begin
            txrqst_q[i] <= 1'b0;
            if (cfg_q[i].txie) intpnd_q[i] <= 1'b1;
          end
          // store placed last so it overrides a same-cycle clear
          if (store && hit_idx == OBJ_W'(i)) begin
            rxid_q[i]   <= rx_id_i;
            dlc_q[i]    <= rx_dlc_i;
            data_q[i]   <= rx_data_i;
            newdat_q[i] <= 1'b1;
            intpnd_q[i] <= 1'b1;
            if (newdat_q[i]) msglst_q[i] <= 1'b1;
          end
        end
      end
    end
  end

  assign rd_id_o   = rxid_q[rd_obj_i];
  assign rd_dlc_o  = dlc_q[rd_obj_i];
  assign rd_data_o = data_q[rd_obj_i];
  assign newdat_o  = newdat_q;
  assign intpnd_o  = intpnd_q;
  assign msglst_o  = msglst_q;
  assign txrqst_o  = txrqst_q;

  logic cfg_on_hit, cfg_on_tx;
  assign cfg_on_hit = cfg_we_i && cfg_obj_i == hit_idx;
  assign cfg_on_tx  = cfg_we_i && cfg_obj_i == tx_obj_i;

  // R3
  store_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store && !cfg_on_hit) |=> (newdat_q[$past(hit_idx)] && intpnd_q[$past(hit_idx)]));

  // R5
  overwrite_lost_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store && !cfg_on_hit && newdat_q[hit_idx]) |=> msglst_q[$past(hit_idx)]);

  // R2
  no_match_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !hit && !cfg_we_i && !clr_i && !tx_done_i)
      |=> ($stable(newdat_q) && $stable(intpnd_q) && $stable(msglst_q)));

  // R10
  tx_done_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && txrqst_q[tx_obj_i] && !cfg_on_tx) |=> !txrqst_q[$past(tx_obj_i)]);
endmodule

// File: tb/sim_rx_obj_bank.sv
module sim_rx_obj_bank;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic        cfg_we_i = 0, cfg_valid_i = 0, cfg_tx_i = 0, cfg_umask_i = 0;
  logic        cfg_rxie_i = 0, cfg_txie_i = 0, cfg_eob_i = 0, cfg_txrqst_i = 0;
  logic [4:0]  cfg_obj_i = 0, clr_obj_i = 0, tx_obj_i = 0, rd_obj_i = 0;
  logic [28:0] cfg_id_i = 0, cfg_mask_i = 0, rx_id_i = 0;
  logic        rx_valid_i = 0, clr_i = 0, clr_newdat_i = 0, clr_intpnd_i = 0;
  logic        clr_msglst_i = 0, tx_done_i = 0, stat_int_i = 0;
  logic [3:0]  rx_dlc_i = 0;
  logic [63:0] rx_data_i = 0;
  logic [28:0] rd_id_o;
  logic [3:0]  rd_dlc_o;
  logic [63:0] rd_data_o;
  logic [31:0] newdat_o, intpnd_o, msglst_o, txrqst_o;
  logic [15:0] int_id_o;

  rx_obj_bank u0 (.*);

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  task automatic cfg(input int obj, input bit tx, input logic [28:0] id,
                     input logic [28:0] mask, input bit um, input bit rxie,
                     input bit txie, input bit eob, input bit rq);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_obj_i = 5'(obj); cfg_valid_i = 1; cfg_tx_i = tx;
    cfg_id_i = id; cfg_mask_i = mask; cfg_umask_i = um; cfg_rxie_i = rxie;
    cfg_txie_i = txie; cfg_eob_i = eob; cfg_txrqst_i = rq;
    step();
    cfg_we_i = 0;
  endtask

  function automatic logic [63:0] pay(logic [28:0] id);
    return {3'b0, id, 3'b0, id};
  endfunction

  task automatic set_rx(input logic [28:0] id, input logic [63:0] d);
    rx_valid_i = 1; rx_id_i = id; rx_dlc_i = id[3:0]; rx_data_i = d;
  endtask

  task automatic do_rx(input logic [28:0] id, input logic [63:0] d);
    @(negedge clk_i);
    set_rx(id, d);
    step();
    rx_valid_i = 0;
  endtask

  task automatic do_clr(input int obj, input bit nd, input bit ip, input bit ml);
    @(negedge clk_i);
    clr_i = 1; clr_obj_i = 5'(obj); clr_newdat_i = nd; clr_intpnd_i = ip; clr_msglst_i = ml;
    step();
    clr_i = 0;
  endtask

  typedef struct packed {
    logic [28:0] id;
    logic [4:0]  rd;
    logic [28:0] rd_id;
    logic [31:0] nd;
    logic [31:0] ml;
    logic [15:0] iid;
  } vec_t;

  // group 0..2 accepts 0x100-0x1FF, obj 5 exact 0x2AA with rx irq off, obj 8 transmit
  localparam vec_t TBL [7] = '{
    '{29'h105, 5'd0, 29'h105, 32'h01, 32'h0, 16'd1},
    '{29'h1FF, 5'd1, 29'h1FF, 32'h03, 32'h0, 16'd1},
    '{29'h300, 5'd0, 29'h105, 32'h03, 32'h0, 16'd1},
    '{29'h2AA, 5'd5, 29'h2AA, 32'h23, 32'h0, 16'd1},
    '{29'h2AB, 5'd5, 29'h2AA, 32'h23, 32'h0, 16'd1},
    '{29'h110, 5'd2, 29'h110, 32'h27, 32'h0, 16'd1},
    '{29'h120, 5'd2, 29'h120, 32'h27, 32'h4, 16'd1}
  };

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    chk("R1 newdat", 64'(newdat_o), 0);
    chk("R1 intpnd", 64'(intpnd_o), 0);
    chk("R1 msglst", 64'(msglst_o), 0);
    chk("R1 txrqst", 64'(txrqst_o), 0);
    chk("R1 int_id", 64'(int_id_o), 0);
    @(negedge clk_i); rst_ni = 1;

    cfg(0, 0, 29'h100, 29'h1FFFFF00, 1, 1, 0, 0, 0);
    cfg(1, 0, 29'h100, 29'h1FFFFF00, 1, 1, 0, 0, 0);
    cfg(2, 0, 29'h100, 29'h1FFFFF00, 1, 1, 0, 1, 0);
    cfg(5, 0, 29'h2AA, 29'h0, 0, 0, 0, 1, 0);
    // transmit object whose ID would match the group: must never take frames (R2)
    cfg(8, 1, 29'h150, 29'h0, 0, 0, 1, 1, 1);
    chk("R10 txrqst set", 64'(txrqst_o), 64'h100);

    // R2 R3 R4 R5 table walk
    for (int k = 0; k < 7; k++) begin
      do_rx(TBL[k].id, pay(TBL[k].id));
      rd_obj_i = TBL[k].rd; #1;
      chk($sformatf("R3 row%0d newdat", k), 64'(newdat_o), 64'(TBL[k].nd));
      chk($sformatf("R5 row%0d msglst", k), 64'(msglst_o), 64'(TBL[k].ml));
      chk($sformatf("R9 row%0d int_id", k), 64'(int_id_o), 64'(TBL[k].iid));
      chk($sformatf("R3 row%0d rd_id", k), 64'(rd_id_o), 64'(TBL[k].rd_id));
      chk($sformatf("R3 row%0d rd_data", k), rd_data_o, pay(TBL[k].rd_id));
      chk($sformatf("R3 row%0d rd_dlc", k), 64'(rd_dlc_o), 64'(TBL[k].rd_id[3:0]));
      chk($sformatf("R2 row%0d txrqst", k), 64'(txrqst_o), 64'h100);
    end

    // R7 clear pending on obj 0, next lowest reported (R9)
    do_clr(0, 0, 1, 0);
    chk("R7 intpnd cleared", 64'(intpnd_o), 64'h26);
    chk("R9 next lowest", 64'(int_id_o), 2);
    do_clr(1, 0, 1, 0);
    do_clr(2, 0, 1, 0);
    chk("R9 disabled pending ignored", 64'(int_id_o), 0);
    chk("R9 obj5 still pending", 64'(intpnd_o), 64'h20);

    // R10 transmit done
    @(negedge clk_i); tx_done_i = 1; tx_obj_i = 5'd8; step(); tx_done_i = 0;
    chk("R10 txrqst cleared", 64'(txrqst_o), 0);
    chk("R10 tx pending", 64'(intpnd_o), 64'h120);
    chk("R10 int_id tx", 64'(int_id_o), 9);

    // R8 status priority
    @(negedge clk_i); stat_int_i = 1; #1;
    chk("R8 status code", 64'(int_id_o), 64'h8000);
    @(negedge clk_i); stat_int_i = 0; #1;
    chk("R8 status released", 64'(int_id_o), 9);

    // R4 freed head object takes the next frame
    do_clr(0, 1, 0, 0);
    chk("R7 newdat cleared", 64'(newdat_o), 64'h26);
    do_rx(29'h150, pay(29'h150));
    rd_obj_i = 0; #1;
    chk("R4 refill head", 64'(rd_id_o), 64'h150);
    chk("R4 newdat", 64'(newdat_o), 64'h27);

    // R7 store wins over same-cycle clear on obj 2 (R5 overwrite)
    @(negedge clk_i);
    clr_i = 1; clr_obj_i = 5'd2; clr_intpnd_i = 1; clr_newdat_i = 0; clr_msglst_i = 0;
    set_rx(29'h170, pay(29'h170));
    step();
    clr_i = 0; rx_valid_i = 0;
    rd_obj_i = 2; #1;
    chk("R7 store beats clear", 64'(intpnd_o[2]), 1);
    chk("R5 tail overwritten", 64'(rd_id_o), 64'h170);
    chk("R5 msglst kept", 64'(msglst_o), 64'h4);

    // R11 config write clears flags
    cfg(2, 0, 29'h100, 29'h1FFFFF00, 1, 1, 0, 1, 0);
    chk("R11 newdat", 64'(newdat_o[2]), 0);
    chk("R11 intpnd", 64'(intpnd_o[2]), 0);
    chk("R11 msglst", 64'(msglst_o[2]), 0);

    // R6 group without a tail drops on full
    cfg(10, 0, 29'h400, 29'h0, 0, 1, 0, 0, 0);
    do_rx(29'h400, 64'hAAAA);
    do_rx(29'h400, 64'hBBBB);
    rd_obj_i = 10; #1;
    chk("R6 kept first", rd_data_o, 64'hAAAA);
    chk("R6 no msglst", 64'(msglst_o[10]), 0);
    chk("R6 newdat", 64'(newdat_o[10]), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule